// File: doc/BRIEF.md
# Serial Two-Wire Register Bridge

This block is a two-wire serial (I2C) target that gives an external host reach into a 32-bit-wide internal register space with 16-bit addresses. The host never touches that space directly. It sees a 16-byte window at the top of an 8-bit offset space. It fills in an address and, for stores, four data bytes. It then starts the internal access by reading one of two trigger bytes. After that it polls a status byte until the access has finished.

Behind the window the block drives a simple register bus. The bus carries a latched address and write data, a read enable, a write enable, returned read data, a ready and an error flag. Only one access is ever in flight. An enable stays high until the target answers or a cycle budget runs out, and the outcome shows up as a status code. The window keeps two status bytes: one for loads and one for stores.

The device address is a fixed 7-bit base plus a one-bit strap input, so two bridges can share one serial bus. The serial interface is oversampled by the system clock.

Top module: `i2cbr_top`

## Requirements
- R1: The target acknowledges only the 7-bit device address 0x66 plus `instStrap` (0x66 or 0x67). It never pulls SDA for any other address, and it changes its own SDA drive only while the synchronized SCL is low.
- R2: In a write transfer, the first data byte sets the window offset. Every further byte written or read advances the offset by one, wrapping from 0xFF to 0x00, so one transfer can fill or read several consecutive bytes.
- R3: Offsets 0xF0 and 0xF1 hold the load address (high byte, then low). Offsets 0xF2 and 0xF3 hold the store address (high, then low). All four bytes can be written and read back.
- R4: Offsets 0xF8 to 0xFB hold the store data, most significant byte first, and can be read back. Offsets 0xF4 to 0xF7 return the last loaded word, most significant byte first, and ignore writes.
- R5: Reading offset 0xFC starts a load at the load address and returns the load status as it stood before the start. Reading 0xFD returns the load status and starts nothing. Writing either offset starts nothing.
- R6: Reading offset 0xFE starts a store of the store data at the store address and returns the store status as it stood before the start. Reading 0xFF returns the store status only.
- R7: The load status is 0xFF after reset, 0x01 while pending, 0x00 on success and 0x02 on failure. A successful load captures the returned word for offsets 0xF4 to 0xF7.
- R8: The store status is 0xFF after reset, 0x05 while pending, 0x04 on success and 0x06 on failure. A successful store presents the store address and data on the bus.
- R9: A ready that comes with the error flag ends the access with the failure code of its kind.
- R10: An enable that sees no ready within TIMEOUT_CYC cycles (256 by default) is dropped after exactly that many cycles, and the access reports the failure code.
- R11: A start issued while an access is in flight starts nothing. It returns the current status of its own kind, which is the pending code when the running access is of the same kind.
- R12: Offsets 0x00 to 0xEF read as 0x00 and ignore writes.
- R13: After reset both enables are low. At most one enable is high at a time. An enable rises one cycle after the trigger byte is fetched and stays high for the latency plus one cycle. Address and write data hold still for the whole access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also used to oversample the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| instStrap | input | 1 | Added to the base device address 0x66 |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | High pulls SDA low (open-drain drive) |
| busAddr | output | 16 | Address of the internal access |
| busWdata | output | 32 | Data of an internal store |
| busWrEn | output | 1 | Store request, held until completion |
| busRdEn | output | 1 | Load request, held until completion |
| busRdata | input | 32 | Data returned by a load |
| busReady | input | 1 | Target completes the access in this cycle |
| busErr | input | 1 | Qualifies busReady as a failed access |

## Verification
Serial results depend on bit timing. A status byte fetched by a trigger read reflects the state at the fetch edge, and the enable it causes is visible from the following clock. So the bench compares the returned byte with the status from before the start and only judges completion through later polls. Bus-side results are timed in cycles. The bench's bus model answers when its wait counter equals the programmed latency and records each enable's length when it falls. The expected length is latency plus one cycles for an answered access and exactly TIMEOUT_CYC cycles for an unanswered one. All serial lines are driven and sampled on the falling clock edge, clear of the edges where the block registers.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  // Byte-level commands from the serial engine to the window datapath
  typedef struct packed {
    logic       setPtr;   // first written byte: new offset
    logic       putByte;  // data byte written at the offset
    logic       takeByte; // byte at the offset handed to the host
    logic [7:0] val;      // received byte
  } winCmd_t;

  localparam logic [7:0] LD_IDLE = 8'hFF;
  localparam logic [7:0] LD_PEND = 8'h01;
  localparam logic [7:0] LD_FAIL = 8'h02;
  localparam logic [7:0] LD_OK   = 8'h00;
  localparam logic [7:0] ST_IDLE = 8'hFF;
  localparam logic [7:0] ST_PEND = 8'h05;
  localparam logic [7:0] ST_FAIL = 8'h06;
  localparam logic [7:0] ST_OK   = 8'h04;

endpackage

// File: rtl/i2cbr_ctrl.sv
module i2cbr_ctrl
  import i2cbr_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'h66,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       instStrap,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] winRdByte,
  output logic       sdaOe,
  output winCmd_t    cmd
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK
  } phase_t;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclQ, sdaQ, sclPrev, sdaPrev;
  logic sclRise, sclFall, startSeen, stopSeen;
  phase_t phase;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg, txReg;
  logic rnw, firstByte, hostNack, loadTx;
  logic [6:0] myAddr;

  assign sclQ = sclSync[SYNC_STAGES-1];
  assign sdaQ = sdaSync[SYNC_STAGES-1];
  assign sclRise = sclQ && !sclPrev;
  assign sclFall = !sclQ && sclPrev;
  assign startSeen = sclQ && sclPrev && sdaPrev && !sdaQ;
  assign stopSeen  = sclQ && sclPrev && !sdaPrev && sdaQ;
  assign myAddr = BASE_ADDR + {6'd0, instStrap};

  assign loadTx = sclFall && ((phase == S_AACK && rnw) || (phase == S_RACK && !hostNack));

  always_comb begin
    cmd = '0;
    cmd.val = shiftReg;
    cmd.setPtr  = (phase == S_WR) && sclFall && (bitCnt == 4'd8) && firstByte;
    cmd.putByte = (phase == S_WR) && sclFall && (bitCnt == 4'd8) && !firstByte;
    cmd.takeByte = loadTx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclQ;
      sdaPrev <= sdaQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= S_IDLE;
      bitCnt <= '0;
      shiftReg <= '0;
      txReg <= '0;
      rnw <= 1'b0;
      firstByte <= 1'b0;
      hostNack <= 1'b0;
      sdaOe <= 1'b0;
    end else if (startSeen) begin
      phase <= S_ADDR;
      bitCnt <= '0;
      sdaOe <= 1'b0;
    end else if (stopSeen) begin
      phase <= S_IDLE;
      sdaOe <= 1'b0;
    end else begin
      unique case (phase)
        S_IDLE: ;
        S_ADDR, S_WR: begin
          if (sclRise && bitCnt < 4'd8) begin
            shiftReg <= {shiftReg[6:0], sdaQ};
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (phase == S_WR) begin
              phase <= S_WACK;
              sdaOe <= 1'b1;
              firstByte <= 1'b0;
            end else if (shiftReg[7:1] == myAddr) begin
              phase <= S_AACK;
              sdaOe <= 1'b1;
              rnw <= shiftReg[0];
            end else begin
              phase <= S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (sclFall && !rnw) begin
            phase <= S_WR;
            sdaOe <= 1'b0;
            bitCnt <= '0;
            firstByte <= 1'b1;
          end
        end
        S_WACK: begin
          if (sclFall) begin
            phase <= S_WR;
            sdaOe <= 1'b0;
            bitCnt <= '0;
          end
        end
        S_RD: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              phase <= S_RACK;
              sdaOe <= 1'b0;
            end else begin
              bitCnt <= bitCnt + 4'd1;
              txReg <= {txReg[6:0], 1'b0};
              sdaOe <= !txReg[6];
            end
          end
        end
        S_RACK: begin
          if (sclRise) hostNack <= sdaQ;
          else if (sclFall && hostNack) phase <= S_IDLE;
        end
        default: phase <= S_IDLE;
      endcase
      if (loadTx) begin
        phase <= S_RD;
        bitCnt <= '0;
        txReg <= winRdByte;
        sdaOe <= !winRdByte[7];
      end
    end
  end

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclQ); // R1

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.setPtr, cmd.putByte, cmd.takeByte})); // R2

endmodule

// File: rtl/i2cbr_dp.sv
module i2cbr_dp
  import i2cbr_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  winCmd_t           cmd,
  output logic [7:0]        winRdByte,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWrEn,
  output logic              busRdEn,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  input  logic              busErr
);

  localparam int CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int NBYTE = DATA_W / 8;

  logic [7:0] ptr;
  logic [ADDR_W-1:0] ldAddr, stAddr, reqAddr;
  logic [DATA_W-1:0] ldData, stData, reqData;
  logic [7:0] ldStat, stStat;
  logic opBusy, opStore;
  logic [CNT_W-1:0] waitCnt;
  logic inWin, goLoad, goStore;

  assign inWin = (ptr[7:4] == 4'hF);
  assign goLoad  = cmd.takeByte && ptr == 8'hFC && !opBusy;
  assign goStore = cmd.takeByte && ptr == 8'hFE && !opBusy;

  always_comb begin
    winRdByte = '0;
    if (inWin) begin
      unique case (ptr[3:0])
        4'h0: winRdByte = ldAddr[15:8];
        4'h1: winRdByte = ldAddr[7:0];
        4'h2: winRdByte = stAddr[15:8];
        4'h3: winRdByte = stAddr[7:0];
        4'h4, 4'h5, 4'h6, 4'h7:
          winRdByte = ldData[8*(NBYTE-1-int'(ptr[1:0])) +: 8];
        4'h8, 4'h9, 4'hA, 4'hB:
          winRdByte = stData[8*(NBYTE-1-int'(ptr[1:0])) +: 8];
        4'hC, 4'hD: winRdByte = ldStat;
        default: winRdByte = stStat;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      ldAddr <= '0;
      stAddr <= '0;
      stData <= '0;
    end else begin
      if (cmd.setPtr) ptr <= cmd.val;
      else if (cmd.putByte || cmd.takeByte) ptr <= ptr + 8'd1;
      if (cmd.putByte && inWin) begin
        unique case (ptr[3:0])
          4'h0: ldAddr[15:8] <= cmd.val;
          4'h1: ldAddr[7:0]  <= cmd.val;
          4'h2: stAddr[15:8] <= cmd.val;
          4'h3: stAddr[7:0]  <= cmd.val;
          default: ;
        endcase
        for (int b = 0; b < NBYTE; b++)
          if (ptr[3:0] == 4'(8 + b)) stData[8*(NBYTE-1-b) +: 8] <= cmd.val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opBusy <= 1'b0;
      opStore <= 1'b0;
      waitCnt <= '0;
      reqAddr <= '0;
      reqData <= '0;
      ldData <= '0;
      ldStat <= LD_IDLE;
      stStat <= ST_IDLE;
    end else if (goLoad || goStore) begin
      opBusy <= 1'b1;
      opStore <= goStore;
      waitCnt <= '0;
      reqAddr <= goStore ? stAddr : ldAddr;
      reqData <= stData;
      if (goStore) stStat <= ST_PEND;
      else ldStat <= LD_PEND;
    end else if (opBusy) begin
      if (busReady) begin
        opBusy <= 1'b0;
        if (opStore) stStat <= busErr ? ST_FAIL : ST_OK;
        else begin
          ldStat <= busErr ? LD_FAIL : LD_OK;
          if (!busErr) ldData <= busRdata;
        end
      end else if (waitCnt == CNT_W'(TIMEOUT_CYC - 1)) begin
        opBusy <= 1'b0;
        if (opStore) stStat <= ST_FAIL;
        else ldStat <= LD_FAIL;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end

  assign busRdEn  = opBusy && !opStore;
  assign busWrEn  = opBusy && opStore;
  assign busAddr  = reqAddr;
  assign busWdata = reqData;

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn && busWrEn)); // R13

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ((busRdEn && $past(busRdEn)) || (busWrEn && $past(busWrEn)))
      |-> ($stable(busAddr) && $stable(busWdata))); // R13

  AST_LD_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |-> ldStat == LD_PEND); // R7

  AST_ST_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |-> stStat == ST_PEND); // R8

  AST_SILENT_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busRdEn) && !busRdEn && !$past(busReady)) |-> ldStat == LD_FAIL); // R10

endmodule

// File: rtl/i2cbr_top.sv
module i2cbr_top
  import i2cbr_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'h66,
  parameter int         TIMEOUT_CYC = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instStrap,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  output logic [15:0] busAddr,
  output logic [31:0] busWdata,
  output logic        busWrEn,
  output logic        busRdEn,
  input  logic [31:0] busRdata,
  input  logic        busReady,
  input  logic        busErr
);

  winCmd_t cmd;
  logic [7:0] winRdByte;

  i2cbr_ctrl #(.BASE_ADDR(BASE_ADDR), .SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .instStrap(instStrap),
    .sclIn(sclIn), .sdaIn(sdaIn), .winRdByte(winRdByte),
    .sdaOe(sdaOe), .cmd(cmd)
  );

  i2cbr_dp #(.TIMEOUT_CYC(TIMEOUT_CYC)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .winRdByte(winRdByte),
    .busAddr(busAddr), .busWdata(busWdata), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busRdata(busRdata), .busReady(busReady),
    .busErr(busErr)
  );

endmodule

// File: tb/sim_i2cbr_top.sv
`timescale 1ns/1ps
module sim_i2cbr_top;

  localparam int TMO = 1024;
  localparam int Q = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic instStrap = 1'b0;
  bit mLow = 1'b0;
  bit sclM = 1'b1;
  logic sdaOe, busWrEn, busRdEn, busReady, busErr, sdaLine;
  logic [15:0] busAddr;
  logic [31:0] busWdata, busRdata;

  assign sdaLine = !(mLow || sdaOe);

  i2cbr_top #(.TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rstN(rstN), .instStrap(instStrap),
    .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .busAddr(busAddr), .busWdata(busWdata), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busRdata(busRdata), .busReady(busReady),
    .busErr(busErr)
  );

  // bus target model
  int lat = 0;
  bit errMode = 1'b0;
  bit deaf = 1'b0;
  int waitC = 0, curLen = 0, lastLen = 0, reqCnt = 0;
  bit reqPrev = 1'b0;
  bit [15:0] capA = '0;
  bit [31:0] capD = '0;
  logic req;
  assign req = busRdEn || busWrEn;
  assign busReady = req && !deaf && (waitC == lat);
  assign busErr = busReady && errMode;
  assign busRdata = {busAddr ^ 16'hA5C3, ~busAddr};

  always @(posedge clk) begin
    reqPrev <= req;
    if (req && !reqPrev) reqCnt <= reqCnt + 1;
    if (req) begin
      waitC <= waitC + 1;
      curLen <= curLen + 1;
    end else begin
      waitC <= 0;
      curLen <= 0;
      if (reqPrev) lastLen <= curLen;
    end
    if (busReady && busWrEn) begin
      capA <= busAddr;
      capD <= busWdata;
    end
  end

  int nChk = 0, nFail = 0;
  logic [6:0] dev = 7'h66;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    mLow = 1'b0; hq(); sclM = 1'b1; hq(); mLow = 1'b1; hq(); sclM = 1'b0; hq();
  endtask

  task automatic i2cStop();
    mLow = 1'b1; hq(); sclM = 1'b1; hq(); mLow = 1'b0; hq(); hq();
  endtask

  task automatic putBit(input bit b);
    mLow = !b; hq(); sclM = 1'b1; hq(); hq(); sclM = 1'b0; hq();
  endtask

  task automatic getBit(output bit b);
    mLow = 1'b0; hq(); sclM = 1'b1; hq(); b = sdaLine; hq(); sclM = 1'b0; hq();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    getBit(x);
    ack = !x;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      getBit(x);
      b[i] = x;
    end
    putBit(!giveAck);
  endtask

  task automatic probe(input logic [6:0] d, output bit ack);
    i2cStart();
    sendByte({d, 1'b0}, ack);
    i2cStop();
  endtask

  task automatic wrWin(input logic [7:0] ofs, input int n, input logic [31:0] val);
    bit a;
    i2cStart();
    sendByte({dev, 1'b0}, a);
    sendByte(ofs, a);
    for (int i = 0; i < n; i++) sendByte(val[8*(n-1-i) +: 8], a);
    i2cStop();
  endtask

  task automatic rdWin(input logic [7:0] ofs, input int n, output logic [31:0] val);
    bit a;
    logic [7:0] b;
    i2cStart();
    sendByte({dev, 1'b0}, a);
    sendByte(ofs, a);
    i2cStart();
    sendByte({dev, 1'b1}, a);
    val = '0;
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b);
      val = {val[23:0], b};
    end
    i2cStop();
  endtask

  task automatic pollStat(input logic [7:0] ofs, input logic [7:0] pend, output logic [31:0] v);
    for (int i = 0; i < 40; i++) begin
      rdWin(ofs, 1, v);
      if (v != {24'd0, pend}) break;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    bit ack;
    int c0;
    logic [15:0] ra, wa;
    logic [31:0] d;
    logic [7:0] prevLd, prevSt;

    repeat (5) @(negedge clk);
    chk("R13 enables low in reset", {30'd0, busRdEn, busWrEn}, 32'd0);
    chk("R1 no drive in reset", {31'd0, sdaOe}, 32'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 addressing
    probe(7'h67, ack); chk("R1 foreign address nack", {31'd0, ack}, 32'd0);
    probe(7'h66, ack); chk("R1 own address ack", {31'd0, ack}, 32'd1);

    // R7 R8 initial codes, R2 wrap of offset
    rdWin(8'hFD, 1, v); chk("R7 initial load status", v, 32'hFF);
    rdWin(8'hFF, 1, v); chk("R8 initial store status", v, 32'hFF);
    rdWin(8'hFF, 2, v); chk("R2 offset wraps to 0x00", v, 32'hFF00);

    // R12 outside window, R4 read-only load data, R5 writes to trigger ignored
    rdWin(8'h10, 1, v); chk("R12 outside reads zero", v, 32'h0);
    wrWin(8'h10, 1, 32'h5A);
    rdWin(8'h10, 1, v); chk("R12 outside write ignored", v, 32'h0);
    wrWin(8'hF4, 4, 32'hDEADBEEF);
    rdWin(8'hF4, 4, v); chk("R4 load data ignores writes", v, 32'h0);
    wrWin(8'hFC, 4, 32'h01010101);
    rdWin(8'hFD, 1, v); chk("R5 written trigger starts nothing", v, 32'hFF);
    chk("R5 no bus access from writes", reqCnt, 32'd0);

    // sweep of latency and patterns
    for (int k = 0; k < 4; k++) begin
      lat = k;
      ra = 16'h1000 * 16'(k) + 16'h0357 + 16'(k);
      wa = ~ra ^ 16'h00F0;
      d = 32'h01234567 * 32'(k + 3);
      prevLd = (k == 0) ? 8'hFF : 8'h00;
      prevSt = (k == 0) ? 8'hFF : 8'h04;
      wrWin(8'hF0, 4, {ra, wa});
      rdWin(8'hF0, 4, v); chk("R3 address bytes read back", v, {ra, wa});
      wrWin(8'hF8, 4, d);
      rdWin(8'hF8, 4, v); chk("R4 store data read back", v, d);

      c0 = reqCnt;
      rdWin(8'hFC, 1, v); chk("R5 load start returns prior status", v, {24'd0, prevLd});
      pollStat(8'hFD, 8'h01, v); chk("R7 load success code", v, 32'h00);
      rdWin(8'hF4, 4, v); chk("R7 loaded word", v, {ra ^ 16'hA5C3, ~ra});
      chk("R13 load enable length", lastLen, 32'(k + 1));
      chk("R5 one load access", reqCnt, 32'(c0 + 1));

      rdWin(8'hFE, 1, v); chk("R6 store start returns prior status", v, {24'd0, prevSt});
      pollStat(8'hFF, 8'h05, v); chk("R8 store success code", v, 32'h04);
      chk("R8 store address", {16'd0, capA}, {16'd0, wa});
      chk("R8 store data", capD, d);
      chk("R13 store enable length", lastLen, 32'(k + 1));
    end

    // R9 error response
    errMode = 1'b1; lat = 1;
    rdWin(8'hFC, 1, v); chk("R9 load start status", v, 32'h00);
    pollStat(8'hFD, 8'h01, v); chk("R9 load error code", v, 32'h02);
    rdWin(8'hFE, 1, v); chk("R9 store start status", v, 32'h04);
    pollStat(8'hFF, 8'h05, v); chk("R9 store error code", v, 32'h06);
    errMode = 1'b0;

    // R10 timeout
    deaf = 1'b1;
    rdWin(8'hFC, 1, v); chk("R10 start status", v, 32'h02);
    pollStat(8'hFD, 8'h01, v); chk("R10 timeout load code", v, 32'h02);
    chk("R10 enable length at timeout", lastLen, 32'(TMO));

    // R11 start while busy
    c0 = reqCnt;
    rdWin(8'hFE, 1, v); chk("R11 first store start", v, 32'h06);
    rdWin(8'hFE, 1, v); chk("R11 second start returns pending", v, 32'h05);
    pollStat(8'hFF, 8'h05, v); chk("R11 store ends failed", v, 32'h06);
    chk("R11 single access", reqCnt, 32'(c0 + 1));
    c0 = reqCnt;
    rdWin(8'hFE, 1, v);
    rdWin(8'hFC, 1, v); chk("R11 load start during store", v, 32'h02);
    pollStat(8'hFF, 8'h05, v);
    rdWin(8'hFD, 1, v); chk("R11 load status untouched", v, 32'h02);
    chk("R11 cross start ignored", reqCnt, 32'(c0 + 1));
    deaf = 1'b0;

    // R1 strap
    instStrap = 1'b1;
    repeat (4) @(negedge clk);
    probe(7'h66, ack); chk("R1 strap moves address away", {31'd0, ack}, 32'd0);
    probe(7'h67, ack); chk("R1 strapped address ack", {31'd0, ack}, 32'd1);
    dev = 7'h67;
    rdWin(8'hF0, 2, v); chk("R1 strapped access works", v, {16'd0, ra});

    summary();
  end

endmodule